// File: doc/BRIEF.md
# Migration Context Slot Scheduler

This controller sits beside one core of a many-core chip in which threads move from core to core at instruction granularity. The core has a fixed set of execution-context slots. A low block of slots is reserved, one per thread whose home is this core. An upper block is a shared pool for visiting threads. Each cycle the controller looks at the thread context waiting at the head of the network input. It decides whether that context is loaded and into which slot. It also decides whether one resident context leaves, and on which traffic class. The register files, the flit serialisation and the routers are outside the block. The controller only hands out slot indices and outbound commands.

A thread ID is made of two fields. The upper `CORE_W` bits name the thread's home core. The lower `NAT_W` bits select its reserved slot on that core. A visiting thread that finds the pool full forces out a visitor that has made progress or already wants to leave. The forced-out thread always goes home on the eviction class. Home threads are never forced out. This keeps the eviction path free of any dependency on migration traffic.

Top module: `ctx_slot_sched`

## Requirements
- R1: While `rst_n` is low and after it is released, every slot is empty (`slot_valid_o` = 0), `arr_accept_o` = 0 and `out_valid_o` = 0 until stimulus arrives.
- R2: A waiting context whose `arr_tid_i[TID_W-1:NAT_W]` equals `core_id_i` is accepted in the same cycle, into slot `arr_tid_i[NAT_W-1:0]`. That slot reads valid from the next cycle on.
- R3: A home-thread arrival is accepted even when the visitor pool is full and a visitor is eligible for eviction. In that cycle nothing is evicted.
- R4: A visiting arrival is accepted into the lowest-numbered empty visitor slot. Visitor slots are indices `2**NAT_W` to `2**NAT_W+GUEST_SLOTS-1`.
- R5: If a visiting arrival finds the pool full, an eligible visitor is evicted and the arrival waits. The eviction has `out_class_o` = 1, and `out_dest_o` is the evicted thread's home-core field, whatever destination it requested. No migration leaves in that cycle.
- R6: A visitor is eligible for eviction when it is valid, is not marked busy, and either has retired an instruction since it was loaded or requests migration. The retire flag is registered, so a retire pulse takes effect on the next cycle. Loading a slot clears the flag. With no eligible visitor, the arrival waits and is not accepted.
- R7: Home-thread slots are never evicted, whatever their retire or busy state.
- R8: When no eviction occurs, a valid, non-busy slot that requests migration leaves with `out_class_o` = 0 and `out_dest_o` set to its requested core. The slot reads empty from the next cycle on.
- R9: An eviction needs `evict_room_i` = 1 and a migration needs `mig_room_i` = 1, meaning there is room for a whole context. Otherwise that action does not start.
- R10: Eviction picks among eligible visitors, and migration picks among requesting slots, each with its own round-robin pointer. After slot k is granted, the search starts at the slot after k.
- R11: At most one context leaves per cycle, and it always comes from an occupied slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_id_i | input | CORE_W | Index of this core |
| arr_valid_i | input | 1 | A context waits at the head of the input |
| arr_tid_i | input | TID_W | Thread ID of the waiting context |
| arr_accept_o | output | 1 | Waiting context is loaded this cycle |
| arr_slot_o | output | SW | Slot receiving the context |
| retire_i | input | SLOTS | Per slot: an instruction retired this cycle |
| busy_i | input | SLOTS | Per slot: instructions still in flight |
| mig_req_i | input | SLOTS | Per slot: occupant wants to migrate |
| mig_dest_i | input | SLOTS*CORE_W | Per slot requested destination core |
| mig_room_i | input | 1 | Migration class can take a whole context |
| evict_room_i | input | 1 | Eviction class can take a whole context |
| out_valid_o | output | 1 | A context leaves this cycle |
| out_class_o | output | 1 | 0 = migration, 1 = eviction |
| out_slot_o | output | SW | Slot being vacated |
| out_tid_o | output | TID_W | Thread ID of the leaving context |
| out_dest_o | output | CORE_W | Destination core |
| slot_valid_o | output | SLOTS | Slot occupancy |

## Verification
Load and departure decisions (`arr_accept_o`, `arr_slot_o` and all `out_*` outputs) are combinational from the inputs and the slot table. They are due in the cycle the stimulus is applied. The bench drives on the falling edge and checks them two nanoseconds later, before the next rising edge. Occupancy and the retire flag change one rising edge later. So `slot_valid_o` is checked in the following cycle, and a retire pulse is held for one full cycle before the arrival that relies on it is presented. Round-robin order is checked by keeping several requests active over consecutive cycles and checking that the granted slot moves on after each grant.

// File: rtl/ctx_sched_pkg.sv
package ctx_sched_pkg;
  localparam logic CLS_MIGRATE = 1'b0;
  localparam logic CLS_EVICT   = 1'b1;
endpackage

// File: rtl/ctx_rr_pick.sv
// Round-robin picker with its own rotating start pointer.
module ctx_rr_pick #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic         adv_i,
  output logic         gnt_valid_o,
  output logic [IW-1:0] gnt_idx_o
);
  logic [IW-1:0] ptr_q, ptr_d;

  always_comb begin
    int c;
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    for (int i = 0; i < N; i++) begin
      c = (int'(ptr_q) + i) % N;
      if (!gnt_valid_o && req_i[c]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = IW'(c);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (adv_i && gnt_valid_o)
      ptr_d = (gnt_idx_o == IW'(N - 1)) ? '0 : gnt_idx_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // R10: a grant always names a requesting entry
  a_r10_grant_is_request: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid_o |-> req_i[gnt_idx_o]);
  // R10: any request yields a grant
  a_r10_no_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) |-> gnt_valid_o);
endmodule

// File: rtl/ctx_slot_table.sv
// Occupancy, thread ID and progress flag per context slot.
module ctx_slot_table #(
  parameter int SLOTS = 4,
  parameter int TID_W = 3,
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_en_i,
  input  logic [SW-1:0]               load_slot_i,
  input  logic [TID_W-1:0]            load_tid_i,
  input  logic                        free_en_i,
  input  logic [SW-1:0]               free_slot_i,
  input  logic [SLOTS-1:0]            retire_i,
  output logic [SLOTS-1:0]            valid_o,
  output logic [SLOTS-1:0]            prog_o,
  output logic [SLOTS-1:0][TID_W-1:0] tid_o
);
  logic [SLOTS-1:0]            valid_q, valid_d;
  logic [SLOTS-1:0]            prog_q, prog_d;
  logic [SLOTS-1:0][TID_W-1:0] tid_q;

  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      valid_d[s] = valid_q[s];
      prog_d[s]  = prog_q[s] | (valid_q[s] & retire_i[s]);
      if (free_en_i && (free_slot_i == SW'(s))) begin
        valid_d[s] = 1'b0;
        prog_d[s]  = 1'b0;
      end
      if (load_en_i && (load_slot_i == SW'(s))) begin
        valid_d[s] = 1'b1;
        prog_d[s]  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      prog_q  <= '0;
    end else begin
      valid_q <= valid_d;
      prog_q  <= prog_d;
    end
  end

  // thread ID is data: enable-only register, no reset
  always_ff @(posedge clk) begin
    if (load_en_i) tid_q[load_slot_i] <= load_tid_i;
  end

  assign valid_o = valid_q;
  assign prog_o  = prog_q;
  assign tid_o   = tid_q;

  // R2: a load only targets an empty slot, which then holds the thread
  a_r2_load_into_empty: assert property (@(posedge clk) disable iff (!rst_n)
    load_en_i |-> !valid_q[load_slot_i]);
  a_r2_load_sets: assert property (@(posedge clk) disable iff (!rst_n)
    load_en_i |=> valid_q[$past(load_slot_i)] && (tid_q[$past(load_slot_i)] == $past(load_tid_i)));
  // R6: progress flag starts clear after a load
  a_r6_prog_clear_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_en_i |=> !prog_q[$past(load_slot_i)]);
  // R8: a departing slot reads empty next cycle
  a_r8_free_clears: assert property (@(posedge clk) disable iff (!rst_n)
    free_en_i |=> !valid_q[$past(free_slot_i)]);
endmodule

// File: rtl/ctx_slot_sched.sv
// Per-core context slot scheduler: home slots plus a visitor pool.
module ctx_slot_sched
  import ctx_sched_pkg::*;
#(
  parameter int CORE_W      = 2,
  parameter int NAT_W       = 1,
  parameter int GUEST_SLOTS = 2,
  localparam int NATIVE_N   = 1 << NAT_W,
  localparam int SLOTS      = NATIVE_N + GUEST_SLOTS,
  localparam int SW         = $clog2(SLOTS),
  localparam int GW         = (GUEST_SLOTS > 1) ? $clog2(GUEST_SLOTS) : 1,
  localparam int TID_W      = CORE_W + NAT_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [CORE_W-1:0]         core_id_i,
  input  logic                      arr_valid_i,
  input  logic [TID_W-1:0]          arr_tid_i,
  output logic                      arr_accept_o,
  output logic [SW-1:0]             arr_slot_o,
  input  logic [SLOTS-1:0]          retire_i,
  input  logic [SLOTS-1:0]          busy_i,
  input  logic [SLOTS-1:0]          mig_req_i,
  input  logic [SLOTS*CORE_W-1:0]   mig_dest_i,
  input  logic                      mig_room_i,
  input  logic                      evict_room_i,
  output logic                      out_valid_o,
  output logic                      out_class_o,
  output logic [SW-1:0]             out_slot_o,
  output logic [TID_W-1:0]          out_tid_o,
  output logic [CORE_W-1:0]         out_dest_o,
  output logic [SLOTS-1:0]          slot_valid_o
);
  logic [SLOTS-1:0]            valid, prog;
  logic [SLOTS-1:0][TID_W-1:0] tid;

  logic                   arr_home;
  logic [GUEST_SLOTS-1:0] g_free, g_elig;
  logic                   has_free;
  logic [GW-1:0]          free_g;
  logic                   ev_v, mg_v;
  logic [GW-1:0]          ev_g;
  logic [SW-1:0]          mg_s;
  logic [SLOTS-1:0]       m_cand;
  logic                   pool_full_wait, do_evict, do_mig;

  assign arr_home = (arr_tid_i[TID_W-1:NAT_W] == core_id_i);

  // visitor pool: free and eviction-eligible vectors
  for (genvar g = 0; g < GUEST_SLOTS; g++) begin : g_pool
    assign g_free[g] = !valid[NATIVE_N+g];
    assign g_elig[g] = valid[NATIVE_N+g] & ~busy_i[NATIVE_N+g]
                     & (prog[NATIVE_N+g] | mig_req_i[NATIVE_N+g]);
  end

  always_comb begin
    has_free = 1'b0;
    free_g   = '0;
    for (int g = GUEST_SLOTS - 1; g >= 0; g--) begin
      if (g_free[g]) begin
        has_free = 1'b1;
        free_g   = GW'(g);
      end
    end
  end

  assign m_cand = valid & mig_req_i & ~busy_i;

  ctx_rr_pick #(.N(GUEST_SLOTS)) i_evict_pick (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (g_elig),
    .adv_i       (do_evict),
    .gnt_valid_o (ev_v),
    .gnt_idx_o   (ev_g)
  );

  ctx_rr_pick #(.N(SLOTS)) i_mig_pick (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (m_cand),
    .adv_i       (do_mig),
    .gnt_valid_o (mg_v),
    .gnt_idx_o   (mg_s)
  );

  // arrival handling: home slot first, then a free visitor slot
  always_comb begin
    arr_accept_o = 1'b0;
    arr_slot_o   = '0;
    if (arr_valid_i) begin
      if (arr_home) begin
        arr_accept_o = !valid[arr_tid_i[NAT_W-1:0]];
        arr_slot_o   = SW'(arr_tid_i[NAT_W-1:0]);
      end else if (has_free) begin
        arr_accept_o = 1'b1;
        arr_slot_o   = SW'(NATIVE_N) + SW'(free_g);
      end
    end
  end

  assign pool_full_wait = arr_valid_i && !arr_home && !has_free;
  assign do_evict       = pool_full_wait && ev_v && evict_room_i;
  assign do_mig         = !do_evict && mg_v && mig_room_i;

  // outbound command
  always_comb begin
    out_valid_o = do_evict | do_mig;
    out_class_o = do_evict ? CLS_EVICT : CLS_MIGRATE;
    out_slot_o  = do_evict ? (SW'(NATIVE_N) + SW'(ev_g)) : mg_s;
    out_tid_o   = tid[out_slot_o];
    out_dest_o  = do_evict ? tid[out_slot_o][TID_W-1:NAT_W]
                           : mig_dest_i[int'(out_slot_o)*CORE_W +: CORE_W];
  end

  ctx_slot_table #(.SLOTS(SLOTS), .TID_W(TID_W)) i_table (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_en_i   (arr_accept_o),
    .load_slot_i (arr_slot_o),
    .load_tid_i  (arr_tid_i),
    .free_en_i   (out_valid_o),
    .free_slot_i (out_slot_o),
    .retire_i    (retire_i),
    .valid_o     (valid),
    .prog_o      (prog),
    .tid_o       (tid)
  );

  assign slot_valid_o = valid;

  // R3: a home arrival is never held back by the visitor pool
  a_r3_home_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid_i && arr_home && !slot_valid_o[arr_tid_i[NAT_W-1:0]]) |-> arr_accept_o && !(out_valid_o && out_class_o == CLS_EVICT));
  // R5: an eviction holds the arrival and heads home
  a_r5_evict_holds_arrival: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_class_o == CLS_EVICT) |-> !arr_accept_o && (out_dest_o == out_tid_o[TID_W-1:NAT_W]));
  // R6: victim made progress or wants out, and is idle
  a_r6_victim_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_class_o == CLS_EVICT) |-> !busy_i[out_slot_o] && (prog[out_slot_o] || mig_req_i[out_slot_o]));
  // R7: home slots never evicted
  a_r7_home_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_class_o == CLS_EVICT) |-> (out_slot_o >= SW'(NATIVE_N)));
  // R9: each class starts only with room for a whole context
  a_r9_mig_room: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_class_o == CLS_MIGRATE) |-> mig_room_i && mig_req_i[out_slot_o]);
  a_r9_evict_room: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_class_o == CLS_EVICT) |-> evict_room_i);
  // R11: departures only from occupied slots
  a_r11_from_occupied: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> slot_valid_o[out_slot_o]);
endmodule

// File: tb/test_ctx_slot_sched.sv
module test_ctx_slot_sched;
  localparam int CORE_W = 2, NAT_W = 1, GUEST_SLOTS = 2;
  localparam int SLOTS = 4, SW = 2, TID_W = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [CORE_W-1:0] core_id;
  logic arr_valid;
  logic [TID_W-1:0] arr_tid;
  logic arr_accept;
  logic [SW-1:0] arr_slot;
  logic [SLOTS-1:0] retire, busy, mig_req;
  logic [SLOTS*CORE_W-1:0] mig_dest;
  logic mig_room, evict_room;
  logic out_valid, out_class;
  logic [SW-1:0] out_slot;
  logic [TID_W-1:0] out_tid;
  logic [CORE_W-1:0] out_dest;
  logic [SLOTS-1:0] slot_valid;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ctx_slot_sched #(.CORE_W(CORE_W), .NAT_W(NAT_W), .GUEST_SLOTS(GUEST_SLOTS)) i_ctx_slot_sched (
    .clk(clk), .rst_n(rst_n), .core_id_i(core_id),
    .arr_valid_i(arr_valid), .arr_tid_i(arr_tid),
    .arr_accept_o(arr_accept), .arr_slot_o(arr_slot),
    .retire_i(retire), .busy_i(busy), .mig_req_i(mig_req), .mig_dest_i(mig_dest),
    .mig_room_i(mig_room), .evict_room_i(evict_room),
    .out_valid_o(out_valid), .out_class_o(out_class), .out_slot_o(out_slot),
    .out_tid_o(out_tid), .out_dest_o(out_dest), .slot_valid_o(slot_valid));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #2;
  endtask

  task automatic present(int t);
    arr_valid = 1'b1;
    arr_tid = TID_W'(t);
    #0;
  endtask

  task automatic idle_arr();
    arr_valid = 1'b0;
    arr_tid = '0;
  endtask

  task automatic expect_out(string tag, int cls, int slot, int t, int dest);
    chk({tag, " out_valid"}, int'(out_valid), 1);
    chk({tag, " class"}, int'(out_class), cls);
    chk({tag, " slot"}, int'(out_slot), slot);
    chk({tag, " tid"}, int'(out_tid), t);
    chk({tag, " dest"}, int'(out_dest), dest);
  endtask

  task automatic pulse_retire(int s);
    retire = '0;
    retire[s] = 1'b1;
    tick();
    retire = '0;
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; core_id = 2'd1; idle_arr();
    retire = '0; busy = '0; mig_req = '0;
    mig_dest = 8'h1B;   // slot s requests core 3-s
    mig_room = 1'b0; evict_room = 1'b1;
    repeat (3) @(posedge clk);
    tick();
    chk("R1 slots empty in reset", int'(slot_valid), 0);
    rst_n = 1'b1;
    tick();
    chk("R1 slots empty", int'(slot_valid), 0);
    chk("R1 no accept", int'(arr_accept), 0);
    chk("R1 no out", int'(out_valid), 0);

    // R2: home threads 2 and 3 land in slots 0 and 1
    for (int t = 2; t < 4; t++) begin
      present(t); #1;
      chk("R2 home accept", int'(arr_accept), 1);
      chk("R2 home slot", int'(arr_slot), t % 2);
      tick();
      idle_arr();
      chk("R2 slot valid", int'(slot_valid[t % 2]), 1);
    end

    // R4: visitors take the lowest free visitor slot
    present(0); #1;
    chk("R4 accept", int'(arr_accept), 1);
    chk("R4 lowest slot", int'(arr_slot), 2);
    tick();
    present(5); #1;
    chk("R4 next slot", int'(arr_slot), 3);
    tick(); idle_arr();
    chk("R4 all full", int'(slot_valid), 15);

    // R6: visitors with no progress are not evicted
    present(6); #1;
    chk("R6 stall accept", int'(arr_accept), 0);
    chk("R6 stall no out", int'(out_valid), 0);
    tick(); idle_arr();
    chk("R6 occupancy kept", int'(slot_valid), 15);

    // R7: home slots that retired are still never evicted
    retire = 4'b0011; tick(); retire = '0;
    present(6); #1;
    chk("R7 no evict of home", int'(out_valid), 0);
    chk("R7 arrival waits", int'(arr_accept), 0);
    idle_arr();

    // R6: busy visitor is not eligible
    pulse_retire(3);
    busy[3] = 1'b1;
    present(6); #1;
    chk("R6 busy blocks evict", int'(out_valid), 0);
    busy[3] = 1'b0; mig_req[0] = 1'b1; mig_room = 1'b1; #1;
    // R5: evict slot 3 (tid 5) home core 2, migration suppressed
    expect_out("R5 evict", 1, 3, 5, 2);
    chk("R5 arrival held", int'(arr_accept), 0);
    mig_room = 1'b0;
    tick();
    chk("R8 evicted slot empty", int'(slot_valid), 7);
    // R9: accept into freed slot, migration blocked by no room
    chk("R4 freed slot", int'(arr_slot), 3);
    chk("R4 accept after evict", int'(arr_accept), 1);
    chk("R9 no mig room", int'(out_valid), 0);
    tick(); idle_arr();
    mig_room = 1'b1; #1;
    expect_out("R8 migrate", 0, 0, 2, 3);
    tick(); mig_req = '0;
    chk("R8 slot freed", int'(slot_valid), 14);

    // R9: eviction needs eviction room
    present(2); #1;
    chk("R2 home reload", int'(arr_accept), 1);
    tick(); idle_arr();
    pulse_retire(2);
    evict_room = 1'b0;
    present(7); #1;
    chk("R9 no evict room", int'(out_valid), 0);
    chk("R9 arrival waits", int'(arr_accept), 0);
    evict_room = 1'b1; #1;
    expect_out("R9 evict with room", 1, 2, 0, 0);
    tick();
    chk("R4 reload slot", int'(arr_slot), 2);
    tick(); idle_arr();
    chk("R4 full again", int'(slot_valid), 15);

    // R10: migration order is round robin starting after slot 0
    mig_req = 4'hF; #1;
    expect_out("R10 first", 0, 1, 3, 2);
    tick();
    expect_out("R10 second", 0, 2, 7, 1);
    tick();
    expect_out("R10 third", 0, 3, 6, 0);
    tick();
    expect_out("R10 wrap", 0, 0, 2, 3);
    tick(); mig_req = '0;
    chk("R11 all left", int'(slot_valid), 0);
    chk("R11 nothing more", int'(out_valid), 0);

    // refill: slot1=3, slot2=4, slot3=1
    present(3); tick(); present(4); tick(); present(1); tick(); idle_arr();
    chk("R4 refill", int'(slot_valid), 14);
    pulse_retire(2);
    mig_dest = 8'hFF; mig_req[3] = 1'b1; mig_room = 1'b0;
    // R3: home arrival wins while visitors are eligible
    present(2); #1;
    chk("R3 home accept", int'(arr_accept), 1);
    chk("R3 home slot", int'(arr_slot), 0);
    chk("R3 no evict", int'(out_valid), 0);
    tick();
    // R5/R10: visitor wanting core 3 is evicted home to core 0; pointer picks slot 3
    present(0); #1;
    expect_out("R5 home not request", 1, 3, 1, 0);
    tick(); idle_arr();
    chk("R8 evicted gone", int'(slot_valid[3]), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule